// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the architectural state changes a 32-bit RISC core with branch delay slots needs when it enters an exception or interrupt handler. The pipeline presents an entry strobe with a cause code together with the current program counter, the delay-slot flag, the live status and power-management registers, and the vector base configuration. On the clock edge that samples the strobe, the block does several things at once. It saves the return address, the old status word and, for illegal instructions, the faulting address. It produces the rewritten status and power-management words. It computes the handler address and raises a one-cycle taken pulse.

The block also arbitrates two asynchronous request lines, a device interrupt and a tick-timer interrupt, against their enable bits in the status word. It turns the winner into an entry with the matching cause. An explicit entry strobe always takes precedence over both lines. The surrounding core loads the rewritten status and power words when the load pulse is high, clears its delay flag on the delay-clear pulse, drops its load-linked reservation on the reservation-clear pulse, and redirects fetch to the vector.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On an entry, the next cycle shows `entry_taken` high for exactly that cycle, `entry_cause` equal to the cause taken, `esr_q` equal to the `sr_cur` sampled at the entry edge, and `epc_q` equal to `cur_pc`, unless R5 or R6 applies.
- R2: Only cause 7 (illegal instruction) loads `eear_q` with `cur_pc`. Every other entry leaves `eear_q` unchanged.
- R3: `sr_new` equals the sampled status with bit 0 (supervisor) set and bits 1 (timer enable), 2 (interrupt enable), 5 (data translation enable) and 6 (instruction translation enable) cleared. Bit 13 follows R5/R6, and all other bits are copied unchanged.
- R4: On an entry, `pmr_new` equals `pmr_cur` with bit 4 (doze) and bit 5 (sleep) cleared, and `state_load` and `resv_clr` pulse for one cycle.
- R5: When `in_delay` is high at entry, `epc_q` is `cur_pc` minus 4, bit 13 of `sr_new` (delay-slot exception) is set, and `dflag_clr` pulses.
- R6: When `in_delay` is low, bit 13 of `sr_new` is cleared and `dflag_clr` stays low. `epc_q` is `cur_pc` plus 4 for cause 12 (system call) and cause 13 (floating point), and `cur_pc` for any other cause.
- R7: `vec_pc` is the cause shifted left by 8. It is ORed with `evbar` when `evbar_present` is high, and ORed with 0xF0000000 when bit 14 of the sampled status is set.
- R8: With `exc_req` low, `irq_tick` gives an entry with cause 5 only if status bit 1 is set. `irq_ext` gives cause 8 only if status bit 2 is set. When both are eligible, cause 5 wins. With `exc_req` high, both lines are ignored.
- R9: An `exc_req` with cause 0 or a cause above 14 raises `unhandled` for one cycle. It produces no taken pulse and changes no saved register or output word.
- R10: A synchronous active-high `rst` clears all saved registers, output words and pulses to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Synchronous exception entry strobe |
| exc_cause | input | 4 | Cause code for `exc_req` |
| irq_ext | input | 1 | Device interrupt request level |
| irq_tick | input | 1 | Tick-timer interrupt request level |
| cur_pc | input | 32 | Program counter of the faulting or interrupted instruction |
| in_delay | input | 1 | Instruction sits in a branch delay slot |
| sr_cur | input | 16 | Live status register |
| pmr_cur | input | 8 | Live power-management register |
| evbar | input | 32 | Vector base register |
| evbar_present | input | 1 | Configuration: vector base register implemented |
| entry_taken | output | 1 | One-cycle pulse: handler entry performed |
| entry_cause | output | 4 | Cause of the last entry |
| vec_pc | output | 32 | Handler address of the last entry |
| sr_new | output | 16 | Status word to load |
| state_load | output | 1 | Pulse: load `sr_new` and `pmr_new` |
| pmr_new | output | 8 | Power-management word to load |
| dflag_clr | output | 1 | Pulse: clear the core's delay-slot flag |
| resv_clr | output | 1 | Pulse: invalidate load-linked reservation |
| epc_q | output | 32 | Saved return address |
| esr_q | output | 16 | Saved pre-entry status |
| eear_q | output | 32 | Saved effective address |
| unhandled | output | 1 | Pulse: strobe with an undefined cause |

## Verification
The bench targets the return-address corrections. If the delay-slot and post-trap adjustments were swapped or ignored, the handler would return one instruction early, or would re-run a system call forever. It drives both interrupt lines together with mixed enable bits: a wrong priority shows up as cause 8 where 5 is expected, and a missing gate shows up as entries taken while interrupts are masked. Illegal-instruction entries are followed by other causes to catch an effective-address register that is overwritten too often. Causes 0 and 15 are sent to catch a design that vectors on undefined codes or corrupts the saved state.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // status word bit positions
  localparam int SR_SM  = 0;
  localparam int SR_TEE = 1;
  localparam int SR_IEE = 2;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_DSX = 13;
  localparam int SR_EPH = 14;
  // power-management bit positions
  localparam int PMR_DOZE  = 4;
  localparam int PMR_SLEEP = 5;
  // cause codes
  localparam int C_RESET   = 1;
  localparam int C_BUSERR  = 2;
  localparam int C_DPF     = 3;
  localparam int C_IPF     = 4;
  localparam int C_TICK    = 5;
  localparam int C_ALIGN   = 6;
  localparam int C_ILLEGAL = 7;
  localparam int C_EXTINT  = 8;
  localparam int C_DTLB    = 9;
  localparam int C_ITLB    = 10;
  localparam int C_RANGE   = 11;
  localparam int C_SYSCALL = 12;
  localparam int C_FPE     = 13;
  localparam int C_TRAP    = 14;
  localparam int CAUSE_FIRST = C_RESET;
  localparam int CAUSE_LAST  = C_TRAP;
endpackage

// File: rtl/exc_irq_arb.sv
module exc_irq_arb
  import exc_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic               irq_ext,
  input  logic               irq_tick,
  input  logic               iee_en,
  input  logic               tee_en,
  output logic               irq_hit,
  output logic [CAUSE_W-1:0] irq_code
);
  logic ext_ok;
  logic tick_ok;

  assign ext_ok  = irq_ext & iee_en;
  assign tick_ok = irq_tick & tee_en;

  // timer has priority over the device line
  always_comb begin
    irq_hit  = 1'b0;
    irq_code = '0;
    if (tick_ok) begin
      irq_hit  = 1'b1;
      irq_code = CAUSE_W'(C_TICK);
    end else if (ext_ok) begin
      irq_hit  = 1'b1;
      irq_code = CAUSE_W'(C_EXTINT);
    end
  end

  always_comb begin
    AST_TICK_GATED: assert (!(irq_hit && irq_code == CAUSE_W'(C_TICK)) || (irq_tick && tee_en)); // R8
    AST_EXT_GATED: assert (!(irq_hit && irq_code == CAUSE_W'(C_EXTINT)) || (irq_ext && iee_en && !tick_ok)); // R8
  end
endmodule

// File: rtl/exc_save_calc.sv
module exc_save_calc
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SR_W    = 16,
  parameter int CAUSE_W = 4,
  parameter int INSN_B  = 4
) (
  input  logic [XLEN-1:0]    pc,
  input  logic               in_delay,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [SR_W-1:0]    sr_old,
  output logic [XLEN-1:0]    ret_pc,
  output logic [SR_W-1:0]    sr_enter
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_B);

  function automatic logic [XLEN-1:0] f_ret_pc(
    input logic [XLEN-1:0] p, input logic dly, input logic [CAUSE_W-1:0] c);
    logic post_trap;
    post_trap = (c == CAUSE_W'(C_SYSCALL)) || (c == CAUSE_W'(C_FPE));
    if (dly)            return p - STEP;
    else if (post_trap) return p + STEP;
    else                return p;
  endfunction

  function automatic logic [SR_W-1:0] f_sr_enter(
    input logic [SR_W-1:0] s_in, input logic dly);
    logic [SR_W-1:0] s;
    s         = s_in;
    s[SR_SM]  = 1'b1;
    s[SR_TEE] = 1'b0;
    s[SR_IEE] = 1'b0;
    s[SR_DME] = 1'b0;
    s[SR_IME] = 1'b0;
    s[SR_DSX] = dly;
    return s;
  endfunction

  assign ret_pc   = f_ret_pc(pc, in_delay, cause);
  assign sr_enter = f_sr_enter(sr_old, in_delay);
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
  parameter int              XLEN      = 32,
  parameter int              CAUSE_W   = 4,
  parameter int              VEC_SHIFT = 8,
  parameter logic [XLEN-1:0] VEC_HI    = 32'hF000_0000
) (
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    base,
  input  logic               base_en,
  input  logic               hi_en,
  output logic [XLEN-1:0]    vec
);
  function automatic logic [XLEN-1:0] f_vec(
    input logic [CAUSE_W-1:0] c, input logic [XLEN-1:0] b,
    input logic b_en, input logic h_en);
    logic [XLEN-1:0] v;
    v = XLEN'(c) << VEC_SHIFT;
    if (b_en) v = v | b;
    if (h_en) v = v | VEC_HI;
    return v;
  endfunction

  assign vec = f_vec(cause, base, base_en, hi_en);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int SR_W      = 16,
  parameter int PMR_W     = 8,
  parameter int CAUSE_W   = 4,
  parameter int VEC_SHIFT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               irq_ext,
  input  logic               irq_tick,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               in_delay,
  input  logic [SR_W-1:0]    sr_cur,
  input  logic [PMR_W-1:0]   pmr_cur,
  input  logic [XLEN-1:0]    evbar,
  input  logic               evbar_present,
  output logic               entry_taken,
  output logic [CAUSE_W-1:0] entry_cause,
  output logic [XLEN-1:0]    vec_pc,
  output logic [SR_W-1:0]    sr_new,
  output logic               state_load,
  output logic [PMR_W-1:0]   pmr_new,
  output logic               dflag_clr,
  output logic               resv_clr,
  output logic [XLEN-1:0]    epc_q,
  output logic [SR_W-1:0]    esr_q,
  output logic [XLEN-1:0]    eear_q,
  output logic               unhandled
);
  localparam logic [PMR_W-1:0] PMR_KEEP =
    ~((PMR_W'(1) << PMR_DOZE) | (PMR_W'(1) << PMR_SLEEP));
  localparam logic [XLEN-1:0] VEC_HI = {4'hF, {(XLEN-4){1'b0}}};

  // named internal events
  logic               cause_ok;
  logic               req_go;
  logic               req_bad;
  logic               irq_hit;
  logic [CAUSE_W-1:0] irq_code;
  logic               go;
  logic [CAUSE_W-1:0] sel_cause;
  logic [XLEN-1:0]    ret_w;
  logic [SR_W-1:0]    sr_w;
  logic [XLEN-1:0]    vec_w;

  assign cause_ok  = (exc_cause >= CAUSE_W'(CAUSE_FIRST)) &&
                     (exc_cause <= CAUSE_W'(CAUSE_LAST));
  assign req_go    = exc_req & cause_ok;
  assign req_bad   = exc_req & ~cause_ok;
  assign go        = req_go | (~exc_req & irq_hit);
  assign sel_cause = exc_req ? exc_cause : irq_code;

  exc_irq_arb #(.CAUSE_W(CAUSE_W)) u_arb (
    .irq_ext  (irq_ext),
    .irq_tick (irq_tick),
    .iee_en   (sr_cur[SR_IEE]),
    .tee_en   (sr_cur[SR_TEE]),
    .irq_hit  (irq_hit),
    .irq_code (irq_code)
  );

  exc_save_calc #(.XLEN(XLEN), .SR_W(SR_W), .CAUSE_W(CAUSE_W)) u_save (
    .pc       (cur_pc),
    .in_delay (in_delay),
    .cause    (sel_cause),
    .sr_old   (sr_cur),
    .ret_pc   (ret_w),
    .sr_enter (sr_w)
  );

  exc_vec_gen #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_SHIFT(VEC_SHIFT),
                .VEC_HI(VEC_HI)) u_vec (
    .cause   (sel_cause),
    .base    (evbar),
    .base_en (evbar_present),
    .hi_en   (sr_cur[SR_EPH]),
    .vec     (vec_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_taken <= 1'b0;
      entry_cause <= '0;
      vec_pc      <= '0;
      sr_new      <= '0;
      state_load  <= 1'b0;
      pmr_new     <= '0;
      dflag_clr   <= 1'b0;
      resv_clr    <= 1'b0;
      epc_q       <= '0;
      esr_q       <= '0;
      eear_q      <= '0;
      unhandled   <= 1'b0;
    end else begin
      entry_taken <= go;
      state_load  <= go;
      resv_clr    <= go;
      dflag_clr   <= go & in_delay;
      unhandled   <= req_bad;
      if (go) begin
        entry_cause <= sel_cause;
        vec_pc      <= vec_w;
        sr_new      <= sr_w;
        pmr_new     <= pmr_cur & PMR_KEEP;
        epc_q       <= ret_w;
        esr_q       <= sr_cur;
        if (sel_cause == CAUSE_W'(C_ILLEGAL)) eear_q <= cur_pc;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst) !(entry_taken && unhandled)); // R9
  AST_UNH_NO_SAVE: assert property (@(posedge clk) disable iff (rst) unhandled |-> $stable(epc_q) && $stable(esr_q)); // R9
  AST_SUPERVISOR: assert property (@(posedge clk) disable iff (rst) entry_taken |-> sr_new[SR_SM] && !sr_new[SR_IEE] && !sr_new[SR_TEE]); // R3
  AST_DSX_MATCH: assert property (@(posedge clk) disable iff (rst) entry_taken |-> sr_new[SR_DSX] == dflag_clr); // R5
  AST_EEAR_KEEP: assert property (@(posedge clk) disable iff (rst) (entry_taken && entry_cause != CAUSE_W'(C_ILLEGAL)) |-> $stable(eear_q)); // R2
  AST_VEC_LOW: assert property (@(posedge clk) disable iff (rst) entry_taken |-> vec_pc[VEC_SHIFT-1:0] == '0); // R7
  AST_LOAD_PAIR: assert property (@(posedge clk) disable iff (rst) entry_taken == state_load && entry_taken == resv_clr); // R4
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        exc_req;
  logic [3:0]  exc_cause;
  logic        irq_ext, irq_tick;
  logic [31:0] cur_pc;
  logic        in_delay;
  logic [15:0] sr_cur;
  logic [7:0]  pmr_cur;
  logic [31:0] evbar;
  logic        evbar_present;
  logic        entry_taken, state_load, dflag_clr, resv_clr, unhandled;
  logic [3:0]  entry_cause;
  logic [31:0] vec_pc, epc_q, eear_q;
  logic [15:0] sr_new, esr_q;
  logic [7:0]  pmr_new;

  always #2.5 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_cause(exc_cause),
    .irq_ext(irq_ext), .irq_tick(irq_tick), .cur_pc(cur_pc),
    .in_delay(in_delay), .sr_cur(sr_cur), .pmr_cur(pmr_cur),
    .evbar(evbar), .evbar_present(evbar_present),
    .entry_taken(entry_taken), .entry_cause(entry_cause), .vec_pc(vec_pc),
    .sr_new(sr_new), .state_load(state_load), .pmr_new(pmr_new),
    .dflag_clr(dflag_clr), .resv_clr(resv_clr), .epc_q(epc_q),
    .esr_q(esr_q), .eear_q(eear_q), .unhandled(unhandled)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit          m_taken, m_load, m_dclr, m_rclr, m_unh;
  int          m_cause;
  logic [31:0] m_vec, m_epc, m_eear;
  logic [15:0] m_sr, m_esr;
  logic [7:0]  m_pmr;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    int c;
    if (rst) begin
      m_taken = 0; m_load = 0; m_dclr = 0; m_rclr = 0; m_unh = 0;
      m_cause = 0; m_vec = 0; m_epc = 0; m_eear = 0; m_sr = 0; m_esr = 0; m_pmr = 0;
    end else begin
      c = -1;
      m_unh = 0;
      if (exc_req) begin
        if (exc_cause >= 1 && exc_cause <= 14) c = int'(exc_cause);
        else m_unh = 1;
      end else begin
        if (irq_ext && sr_cur[2]) c = 8;
        if (irq_tick && sr_cur[1]) c = 5;
      end
      m_taken = (c >= 0); m_load = m_taken; m_rclr = m_taken;
      m_dclr = m_taken && in_delay;
      if (c >= 0) begin
        m_cause = c;
        m_esr = sr_cur;
        if (in_delay) m_epc = cur_pc - 32'd4;
        else if (c == 12 || c == 13) m_epc = cur_pc + 32'd4;
        else m_epc = cur_pc;
        if (c == 7) m_eear = cur_pc;
        m_sr = sr_cur & ~16'h0066;
        m_sr[0] = 1'b1;
        m_sr[13] = in_delay;
        m_pmr = pmr_cur & 8'hCF;
        m_vec = c * 256;
        if (evbar_present) m_vec = m_vec | evbar;
        if (sr_cur[14]) m_vec = m_vec | 32'hF000_0000;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R1", "entry_taken", {31'd0, entry_taken}, {31'd0, m_taken});
      chk("R1", "entry_cause", {28'd0, entry_cause}, 32'(m_cause));
      chk("R1", "esr_q", {16'd0, esr_q}, {16'd0, m_esr});
      chk("R1/R5/R6", "epc_q", epc_q, m_epc);
      chk("R2", "eear_q", eear_q, m_eear);
      chk("R3", "sr_new", {16'd0, sr_new}, {16'd0, m_sr});
      chk("R4", "pmr_new", {24'd0, pmr_new}, {24'd0, m_pmr});
      chk("R4", "state_load", {31'd0, state_load}, {31'd0, m_load});
      chk("R4", "resv_clr", {31'd0, resv_clr}, {31'd0, m_rclr});
      chk("R5", "dflag_clr", {31'd0, dflag_clr}, {31'd0, m_dclr});
      chk("R7", "vec_pc", vec_pc, m_vec);
      chk("R9", "unhandled", {31'd0, unhandled}, {31'd0, m_unh});
    end
  end

  task automatic idle();
    exc_req = 0; exc_cause = 0; irq_ext = 0; irq_tick = 0; in_delay = 0;
  endtask

  // apply one cycle of stimulus, then return at the negedge after the edge
  task automatic step(input bit req, input logic [3:0] cause, input logic [31:0] pc,
                      input bit dly, input logic [15:0] sr, input bit ie, input bit it);
    exc_req = req; exc_cause = cause; cur_pc = pc; in_delay = dly; sr_cur = sr;
    irq_ext = ie; irq_tick = it;
    @(negedge clk);
    #0.5;
    idle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; idle(); cur_pc = 0; sr_cur = 0; pmr_cur = 0; evbar = 0; evbar_present = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "epc after reset", epc_q, 32'd0);
    chk("R10", "vec after reset", vec_pc, 32'd0);
    chk("R10", "taken after reset", {31'd0, entry_taken}, 32'd0);
    #0.5 rst = 0;

    // R6/R7/R4: system call, base register present
    pmr_cur = 8'hFF; evbar = 32'h0001_0000; evbar_present = 1;
    step(1, 4'd12, 32'h0000_1000, 0, 16'h0066, 0, 0);
    chk("R6", "syscall epc", epc_q, 32'h0000_1004);
    chk("R7", "vec with base", vec_pc, 32'h0001_0C00);
    chk("R3", "sr rewrite", {16'd0, sr_new}, 32'h0000_0001);
    chk("R4", "pmr cleared", {24'd0, pmr_new}, 32'h0000_00CF);
    // R5: delay slot, high vectors, no base
    evbar_present = 0;
    step(1, 4'd6, 32'h0000_2000, 1, 16'h4000, 0, 0);
    chk("R5", "delay epc", epc_q, 32'h0000_1FFC);
    chk("R5", "delay sr", {16'd0, sr_new}, 32'h0000_6001);
    chk("R7", "high vector", vec_pc, 32'hF000_0600);
    // R5: delay slot overrides the syscall correction
    step(1, 4'd12, 32'h0000_2400, 1, 16'h0000, 0, 0);
    chk("R5", "delay syscall epc", epc_q, 32'h0000_23FC);
    // R2: illegal loads eear, later cause keeps it
    step(1, 4'd7, 32'h0000_3000, 0, 16'h0000, 0, 0);
    chk("R2", "eear illegal", eear_q, 32'h0000_3000);
    step(1, 4'd2, 32'h0000_4000, 0, 16'h0000, 0, 0);
    chk("R2", "eear kept", eear_q, 32'h0000_3000);
    // R9: undefined causes
    step(1, 4'd0, 32'h0000_5000, 0, 16'h0000, 1, 1);
    chk("R9", "cause0 unhandled", {31'd0, unhandled}, 32'd1);
    chk("R9", "cause0 no epc", epc_q, 32'h0000_4000);
    step(1, 4'd15, 32'h0000_6000, 0, 16'h0006, 0, 0);
    chk("R9", "cause15 no taken", {31'd0, entry_taken}, 32'd0);
    // R8: priority and gating
    step(0, 4'd0, 32'h0000_7000, 0, 16'h0006, 1, 1);
    chk("R8", "timer wins", {28'd0, entry_cause}, 32'd5);
    step(0, 4'd0, 32'h0000_7100, 0, 16'h0004, 1, 1);
    chk("R8", "ext when timer masked", {28'd0, entry_cause}, 32'd8);
    step(0, 4'd0, 32'h0000_7200, 0, 16'h0000, 1, 1);
    chk("R8", "both masked", {31'd0, entry_taken}, 32'd0);
    step(1, 4'd3, 32'h0000_7300, 0, 16'h0006, 1, 1);
    chk("R8", "strobe beats irqs", {28'd0, entry_cause}, 32'd3);

    // random traffic, model compares every cycle
    for (int i = 0; i < 3000; i++) begin
      pmr_cur = 8'($urandom);
      evbar = {$urandom_range(0, 15) == 0 ? 4'hF : 4'h0, 12'($urandom), 16'h0};
      evbar_present = 1'($urandom);
      step($urandom_range(0, 9) < 4, 4'($urandom), {$urandom_range(0, 65535), 2'b00},
           1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
      if (i == 1500) begin
        rst = 1;
        @(negedge clk);
        chk("R10", "mid-run reset eear", eear_q, 32'd0);
        #0.5 rst = 0;
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule